// File: doc/BRIEF.md
# Batched Priority Memory Request Coordinator

This block sits between four on-chip buffer clients and a single off-chip memory request port. The clients are the edge buffer, the input feature buffer, the weight buffer and the output buffer. Each one hands over read or write requests, each with an address and a length. The block holds each client's requests in its own small queue. It serves the queues in rounds called batches.

A batch opens when no batch is in progress and at least one request is stored. At that moment the block records how many requests each queue holds, and only those requests belong to the batch. The batch is then issued grouped by a fixed client priority: edge first, then input feature, then weight, then output. Requests from one client therefore leave back to back and in arrival order. Requests that arrive while a batch is issuing wait for the next batch, even when they come from a higher-priority client. A low-priority request that is already in the open batch is never overtaken by later traffic.

Each issued address is split for the memory controller. The lowest bits select the channel, the next bits select the bank, and the remaining upper bits form the row. All ports that carry requests follow valid/ready rules. A transfer happens on a clock edge where valid and ready are both high. Once a source raises valid, it holds valid and its payload until the transfer takes place. The block applies the same rule to its output port, so the memory side can stall it for any number of cycles.

Top module: `mem_req_coord`

## Requirements
- R1: While reset is asserted, `out_valid` is 0 and every bit of `in_ready` is 1.
- R2: `in_ready[c]` is high exactly when client c's queue holds fewer than DEPTH requests (default 8). A request offered while its queue is full is not taken.
- R3: A batch contains exactly the requests stored when the batch opens. These are the requests accepted on clock edges before the opening edge. Requests accepted on the opening edge or later wait for a later batch.
- R4: Within a batch, requests leave grouped by client in the priority order edge (`out_client`=0), input feature (1), weight (2), output (3). Client index never decreases inside a batch.
- R5: Each client's requests leave in the order they were accepted, with their address, length and write flag unchanged. Every accepted request is issued exactly once.
- R6: `out_chan` equals `out_addr[CH_W-1:0]` (bits 1:0 by default). `out_bank` equals the next BK_W bits (bits 4:2). `out_row` equals the remaining upper bits (bits 31:5).
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and every output payload field holds its value on the next cycle.
- R8: `out_last` is high exactly on the final request of a batch.
- R9: After the final request of a batch transfers, `out_valid` is low for the next cycle. A new batch opens only when the previous batch has fully drained and a request is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 4 | Request valid, one bit per client (bit 0 edge, 1 input feature, 2 weight, 3 output) |
| in_ready | output | 4 | Request ready, one bit per client |
| in_addr | input | 4*ADDR_W | Request addresses; client c uses slice [c*ADDR_W +: ADDR_W] |
| in_len | input | 4*LEN_W | Request lengths; client c uses slice [c*LEN_W +: LEN_W] |
| in_wr | input | 4 | Write flag per client (1 write, 0 read) |
| out_valid | output | 1 | Issued request valid |
| out_ready | input | 1 | Memory side accepts the issued request |
| out_client | output | 2 | Index of the client that owns the issued request |
| out_addr | output | ADDR_W | Issued address, unchanged |
| out_len | output | LEN_W | Issued length |
| out_wr | output | 1 | Issued write flag |
| out_chan | output | CH_W | Channel select from the lowest address bits |
| out_bank | output | BK_W | Bank select from the bits above the channel field |
| out_row | output | ADDR_W-CH_W-BK_W | Row from the remaining upper address bits |
| out_last | output | 1 | Marks the final request of the current batch |

## Verification
The assertions rely on the clients following the valid/ready rules. In particular, they assume a client does not withdraw a request or change its payload while the request is still waiting. The stimulus holds each client's payload until that request is accepted and draws new values only after a transfer. The out-port stall check assumes the memory side may hold `out_ready` low for any stretch of cycles. The stimulus covers this with long stalls, heavy load that fills all four queues, and a directed case in which high-priority requests arrive just after a low-priority batch has opened.

// File: rtl/mrc_pkg.sv
`timescale 1ns/1ps
package mrc_pkg;

  localparam int unsigned NUM_CLIENTS = 4;

  // client index doubles as its issue priority: lower index leaves first
  typedef enum logic [1:0] {
    CLI_EDGE = 2'd0,
    CLI_FEAT = 2'd1,
    CLI_WGT  = 2'd2,
    CLI_OUT  = 2'd3
  } client_e;

  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_ISSUE = 1'b1
  } phase_e;

endpackage

// File: rtl/mrc_req_fifo.sv
`timescale 1ns/1ps
module mrc_req_fifo #(
  parameter int W     = 41,
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic [CW-1:0] count
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + PW'(1);
  endfunction

  assign full = (count == CW'(DEPTH));
  assign dout = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end

endmodule

// File: rtl/mrc_batch_sched.sv
`timescale 1ns/1ps
module mrc_batch_sched
  import mrc_pkg::*;
#(
  parameter int NCLI = 4,
  parameter int CW   = 4,
  parameter int SW   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCLI*CW-1:0] occ_flat,
  input  logic             fire,
  output logic             active,
  output logic [NCLI-1:0]  grant,
  output logic [SW-1:0]    sel,
  output logic             last,
  output logic [NCLI*CW-1:0] rem_flat
);

  phase_e        phase;
  logic [CW-1:0] occ [NCLI];
  logic [CW-1:0] rem [NCLI];
  logic          pending;
  logic          found;
  logic          more;

  for (genvar g = 0; g < NCLI; g++) begin : g_slice
    assign occ[g] = occ_flat[g*CW +: CW];
    assign rem_flat[g*CW +: CW] = rem[g];
  end

  assign active = (phase == PH_ISSUE);

  always_comb begin
    pending = 1'b0;
    for (int i = 0; i < NCLI; i++) pending = pending | (occ[i] != '0);
  end

  // lowest-index client with batch work left wins
  always_comb begin
    grant = '0;
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < NCLI; i++) begin
      if (!found && rem[i] != '0) begin
        grant[i] = 1'b1;
        sel      = SW'(i);
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    more = 1'b0;
    for (int i = 0; i < NCLI; i++) begin
      if (i > int'(sel) && rem[i] != '0) more = 1'b1;
    end
  end

  assign last = active && (rem[sel] == CW'(1)) && !more;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      for (int i = 0; i < NCLI; i++) rem[i] <= '0;
    end else if (phase == PH_IDLE) begin
      if (pending) begin
        phase <= PH_ISSUE;
        for (int i = 0; i < NCLI; i++) rem[i] <= occ[i];
      end
    end else if (fire) begin
      rem[sel] <= rem[sel] - CW'(1);
      if (last) phase <= PH_IDLE;
    end
  end

endmodule

// File: rtl/mrc_addr_map.sv
`timescale 1ns/1ps
module mrc_addr_map #(
  parameter int ADDR_W = 32,
  parameter int CH_W   = 2,
  parameter int BK_W   = 3,
  parameter int ROW_W  = 27
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [CH_W-1:0]   chan,
  output logic [BK_W-1:0]   bank,
  output logic [ROW_W-1:0]  row
);

  localparam int BK_LO  = CH_W;
  localparam int ROW_LO = CH_W + BK_W;

  assign chan = addr[CH_W-1:0];
  assign bank = addr[BK_LO +: BK_W];
  assign row  = addr[ROW_LO +: ROW_W];

endmodule

// File: rtl/mem_req_coord.sv
`timescale 1ns/1ps
module mem_req_coord
  import mrc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int DEPTH  = 8,
  parameter int CH_W   = 2,
  parameter int BK_W   = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_CLIENTS-1:0]             in_valid,
  output logic [NUM_CLIENTS-1:0]             in_ready,
  input  logic [NUM_CLIENTS*ADDR_W-1:0]      in_addr,
  input  logic [NUM_CLIENTS*LEN_W-1:0]       in_len,
  input  logic [NUM_CLIENTS-1:0]             in_wr,
  output logic                               out_valid,
  input  logic                               out_ready,
  output logic [$clog2(NUM_CLIENTS)-1:0]     out_client,
  output logic [ADDR_W-1:0]                  out_addr,
  output logic [LEN_W-1:0]                   out_len,
  output logic                               out_wr,
  output logic [CH_W-1:0]                    out_chan,
  output logic [BK_W-1:0]                    out_bank,
  output logic [ADDR_W-CH_W-BK_W-1:0]        out_row,
  output logic                               out_last
);

  localparam int NCLI  = NUM_CLIENTS;
  localparam int SW    = $clog2(NCLI);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int EW    = ADDR_W + LEN_W + 1;
  localparam int ROW_W = ADDR_W - CH_W - BK_W;

  logic [NCLI-1:0]    q_full;
  logic [NCLI-1:0]    q_push;
  logic [NCLI-1:0]    q_pop;
  logic [EW-1:0]      q_head [NCLI];
  logic [NCLI*CW-1:0] cnt_flat;
  logic [NCLI*CW-1:0] rem_flat;
  logic [NCLI-1:0]    sched_grant;
  logic [SW-1:0]      sched_sel;
  logic               sched_active;
  logic               sched_last;
  logic               out_fire;
  logic [EW-1:0]      sel_entry;

  assign out_fire = out_valid && out_ready;

  for (genvar g = 0; g < NCLI; g++) begin : g_client
    logic [EW-1:0] entry_in;
    assign entry_in  = {in_wr[g], in_len[g*LEN_W +: LEN_W], in_addr[g*ADDR_W +: ADDR_W]};
    assign in_ready[g] = !q_full[g];
    assign q_push[g]   = in_valid[g] && !q_full[g];
    assign q_pop[g]    = out_fire && sched_grant[g];

    mrc_req_fifo #(
      .W     (EW),
      .DEPTH (DEPTH),
      .CW    (CW)
    ) u_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push[g]),
      .din   (entry_in),
      .full  (q_full[g]),
      .pop   (q_pop[g]),
      .dout  (q_head[g]),
      .count (cnt_flat[g*CW +: CW])
    );
  end

  mrc_batch_sched #(
    .NCLI (NCLI),
    .CW   (CW),
    .SW   (SW)
  ) u_sched (
    .clk      (clk),
    .rst_n    (rst_n),
    .occ_flat (cnt_flat),
    .fire     (out_fire),
    .active   (sched_active),
    .grant    (sched_grant),
    .sel      (sched_sel),
    .last     (sched_last),
    .rem_flat (rem_flat)
  );

  always_comb begin
    sel_entry = '0;
    for (int i = 0; i < NCLI; i++) begin
      if (sched_grant[i]) sel_entry = q_head[i];
    end
  end

  assign out_valid  = sched_active;
  assign out_client = sched_sel;
  assign out_addr   = sel_entry[ADDR_W-1:0];
  assign out_len    = sel_entry[ADDR_W +: LEN_W];
  assign out_wr     = sel_entry[EW-1];
  assign out_last   = sched_last;

  mrc_addr_map #(
    .ADDR_W (ADDR_W),
    .CH_W   (CH_W),
    .BK_W   (BK_W),
    .ROW_W  (ROW_W)
  ) u_map (
    .addr (out_addr),
    .chan (out_chan),
    .bank (out_bank),
    .row  (out_row)
  );

endmodule

// File: rtl/mrc_coord_chk.sv
`timescale 1ns/1ps
module mrc_coord_chk #(
  parameter int NCLI   = 4,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int CW     = 4,
  parameter int SW     = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NCLI-1:0]    in_valid,
  input logic [NCLI-1:0]    in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic               out_last,
  input logic [SW-1:0]      out_client,
  input logic [ADDR_W-1:0]  out_addr,
  input logic [LEN_W-1:0]   out_len,
  input logic               out_wr,
  input logic [NCLI-1:0]    grant,
  input logic [NCLI*CW-1:0] cnt_flat,
  input logic [NCLI*CW-1:0] rem_flat
);

  // R4: issue order never steps back to a higher-priority client inside a batch
  assert_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> (!out_valid || out_client >= $past(out_client)));

  // R4: exactly one queue is selected whenever a request is offered
  assert_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(grant) == 1));

  // R9: a drained batch is followed by one idle cycle
  assert_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);

  // R7: stalled output keeps its request
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_len)
                                   && $stable(out_wr) && $stable(out_client) && $stable(out_last)));

  for (genvar c = 0; c < NCLI; c++) begin : g_chk
    // R3: batch work of a client never exceeds what its queue stores
    assert_batch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rem_flat[c*CW +: CW] <= cnt_flat[c*CW +: CW]);

    // R2: an accepted request is stored
    assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[c] && in_ready[c]) |=> (cnt_flat[c*CW +: CW] != '0));
  end

endmodule

bind mem_req_coord mrc_coord_chk #(
  .NCLI   (NCLI),
  .ADDR_W (ADDR_W),
  .LEN_W  (LEN_W),
  .CW     (CW),
  .SW     (SW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_last   (out_last),
  .out_client (out_client),
  .out_addr   (out_addr),
  .out_len    (out_len),
  .out_wr     (out_wr),
  .grant      (sched_grant),
  .cnt_flat   (cnt_flat),
  .rem_flat   (rem_flat)
);

// File: tb/sim_mem_req_coord.sv
`timescale 1ns/1ps
module sim_mem_req_coord;

  localparam int NC    = 4;
  localparam int AW    = 32;
  localparam int LW    = 8;
  localparam int DEP   = 8;
  localparam int MQ    = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] in_valid = '0;
  logic [NC-1:0] in_ready;
  logic [NC-1:0] in_wr = '0;
  logic [AW-1:0] ad [NC];
  logic [LW-1:0] ln [NC];
  logic [NC*AW-1:0] in_addr;
  logic [NC*LW-1:0] in_len;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [1:0]    out_client;
  logic [AW-1:0] out_addr;
  logic [LW-1:0] out_len;
  logic          out_wr;
  logic [1:0]    out_chan;
  logic [2:0]    out_bank;
  logic [26:0]   out_row;
  logic          out_last;

  always #4 clk = ~clk;

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      in_addr[c*AW +: AW] = ad[c];
      in_len[c*LW +: LW]  = ln[c];
    end
  end

  mem_req_coord u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_len(in_len), .in_wr(in_wr),
    .out_valid(out_valid), .out_ready(out_ready), .out_client(out_client),
    .out_addr(out_addr), .out_len(out_len), .out_wr(out_wr),
    .out_chan(out_chan), .out_bank(out_bank), .out_row(out_row), .out_last(out_last)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference queues of accepted, not yet issued requests
  int          m_t [NC][MQ];
  logic [AW-1:0] m_a [NC][MQ];
  logic [LW-1:0] m_l [NC][MQ];
  logic        m_w [NC][MQ];
  int hd [NC];
  int tl [NC];
  int b_rem [NC];
  logic [NC-1:0] hold_req = '0;
  logic [NC-1:0] acc = '0;
  logic prev_ov = 1'b0, prev_or = 1'b0;
  logic [AW-1:0] p_addr;
  logic [LW-1:0] p_len;
  logic p_wr, p_last;
  logic [1:0] p_cli;
  int log_cli [8];
  int n_log = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int batch_total();
    int s = 0;
    for (int c = 0; c < NC; c++) s += b_rem[c];
    return s;
  endfunction

  function automatic int first_client();
    for (int c = 0; c < NC; c++) if (b_rem[c] > 0) return c;
    return -1;
  endfunction

  task automatic tick();
    int tot;
    int ec;
    #1;
    acc = '0;
    // R3: a rise of out_valid marks a batch opened on the edge just passed
    if (out_valid && !prev_ov) begin
      for (int c = 0; c < NC; c++) begin
        b_rem[c] = 0;
        for (int k = hd[c]; k < tl[c]; k++) if (m_t[c][k % MQ] < cyc) b_rem[c]++;
      end
      check(batch_total() > 0, "R3", "batch opened with nothing pending", 0, 1);
    end
    if (prev_ov && !prev_or) begin
      check(out_valid && out_addr == p_addr && out_len == p_len && out_wr == p_wr
            && out_client == p_cli && out_last == p_last, "R7", "stalled output changed",
            {out_valid, out_addr}, {1'b1, p_addr});
    end
    tot = batch_total();
    check(!(out_valid && tot == 0), "R9", "out_valid outside an open batch", out_valid, 0);
    for (int c = 0; c < NC; c++)
      check(in_ready[c] == ((tl[c] - hd[c]) < DEP), "R2", "in_ready vs stored count",
            in_ready[c], (tl[c] - hd[c]) < DEP);
    if (out_valid && out_ready && tot > 0) begin
      ec = first_client();
      check(out_client == 2'(ec), "R4", "issuing client", out_client, ec);
      check(out_addr == m_a[ec][hd[ec] % MQ] && out_len == m_l[ec][hd[ec] % MQ]
            && out_wr == m_w[ec][hd[ec] % MQ], "R5", "issued payload",
            out_addr, m_a[ec][hd[ec] % MQ]);
      check(out_chan == out_addr[1:0] && out_bank == out_addr[4:2] && out_row == out_addr[31:5],
            "R6", "address split", {out_row, out_bank, out_chan}, out_addr);
      check(out_last == (tot == 1), "R8", "batch end flag", out_last, tot == 1);
      hd[ec]++;
      b_rem[ec]--;
      if (n_log < 8) begin log_cli[n_log] = out_client; n_log++; end
    end
    for (int c = 0; c < NC; c++) begin
      if (in_valid[c] && in_ready[c]) begin
        m_t[c][tl[c] % MQ] = cyc + 1;
        m_a[c][tl[c] % MQ] = ad[c];
        m_l[c][tl[c] % MQ] = ln[c];
        m_w[c][tl[c] % MQ] = in_wr[c];
        tl[c]++;
        acc[c] = 1'b1;
      end
    end
    prev_ov = out_valid; prev_or = out_ready;
    p_addr = out_addr; p_len = out_len; p_wr = out_wr; p_cli = out_client; p_last = out_last;
    @(negedge clk);
    for (int c = 0; c < NC; c++) hold_req[c] = in_valid[c] && !acc[c];
  endtask

  task automatic drive_random(input int pv, input int pr);
    for (int c = 0; c < NC; c++) begin
      if (!hold_req[c]) begin
        in_valid[c] = ($urandom % 100) < pv;
        case ($urandom % 16)
          0:       ad[c] = '0;
          1:       ad[c] = '1;
          default: ad[c] = $urandom;
        endcase
        ln[c]    = LW'($urandom);
        in_wr[c] = (c == 3) ? 1'b1 : (($urandom % 4) == 0);
      end
    end
    out_ready = ($urandom % 100) < pr;
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int c = 0; c < NC; c++) begin hd[c] = 0; tl[c] = 0; b_rem[c] = 0; ad[c] = '0; ln[c] = '0; end
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    check(in_ready == 4'hF, "R1", "in_ready in reset", in_ready, 4'hF);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: low-priority request opens a batch, later high-priority ones wait
    out_ready = 1'b0;
    for (int k = 0; k < 3; k++) begin
      in_valid = 4'b1000; ad[3] = 32'h100 + k; ln[3] = 8'(k + 1); in_wr[3] = 1'b1;
      tick();
    end
    for (int k = 0; k < 2; k++) begin
      in_valid = 4'b0001; ad[0] = 32'h200 + k; ln[0] = 8'(k + 4); in_wr[0] = 1'b0;
      tick();
    end
    in_valid = '0;
    repeat (2) tick();
    out_ready = 1'b1;
    repeat (10) tick();
    check(n_log == 5 && log_cli[0] == 3 && log_cli[1] == 0 && log_cli[2] == 0
          && log_cli[3] == 3 && log_cli[4] == 3, "R3", "directed issue order 3,0,0,3,3",
          {log_cli[0], log_cli[1]}, {32'd3, 32'd0});

    for (int i = 0; i < 1500; i++) begin drive_random(30, 70); tick(); end
    for (int i = 0; i < 1500; i++) begin drive_random(85, 25); tick(); end
    for (int i = 0; i < 1000; i++) begin drive_random(50, (i % 40) < 20 ? 0 : 100); tick(); end

    in_valid = '0;
    out_ready = 1'b1;
    for (int i = 0; i < 200; i++) tick();
    for (int c = 0; c < NC; c++)
      check(tl[c] == hd[c], "R5", "requests left unissued", tl[c] - hd[c], 0);
    check(out_valid == 1'b0, "R9", "idle after drain", out_valid, 0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule